// File: doc/BRIEF.md
# Double-Bank Frame Store with Dual-Lane Serial Output

This block collects the zero-suppressed words produced for one sensor frame and sends the previous frame out over a small number of serial lanes. It holds two memory banks. One bank takes the words of the frame now being built. The other bank, holding the frame that was just closed, drains onto the serial lanes. A start-of-frame pulse closes the bank being written and hands it to the serial side, so readout keeps running from frame to frame.

Words enter through a valid/ready stream. A word moves when `in_valid` and `in_ready` are both high at a rising clock edge. A source that sees `in_ready` low must hold its word and keep `in_valid` high. `in_ready` drops in two cases: when a start-of-frame pulse arrives while a readout is still in progress, and from then until that readout has finished and the delayed bank swap has taken place. The serial side has no back-pressure. Each lane carries one bit per clock cycle.

Every frame is sent as four parts, in this order:
- a header word `{16'hA55A, frame_number[15:0]}`;
- a count word `{16'h0000, stored_count[15:0]}`;
- the stored words;
- a trailer word `{16'h5AA5, 15'b0, overflow}`.

The marker line is high for the bit periods of the header and low at all other times.

Top module: `frame_pingpong_tx`

## Requirements
- R1: While reset is active and in the first cycle after it, `ser_lane` is all zeros, and `ser_mark`, `late_swap` are 0; `in_ready` is 1 when `frame_start` is low.
- R2: A readout consists of four parts in order: the header `{16'hA55A, frame number}`, then the count `{16'h0000, n}`, then n stored words in arrival order, then the trailer `{16'h5AA5, 15'b0, ovf}`. `ser_mark` is 1 during exactly the 16 bit periods of the header.
- R3: Each word takes WORD_W/LANES = 16 consecutive bit periods, MSB first. In bit period t, lane k carries word bit 31-2t-k. Lane 0 therefore carries the even-offset bits, starting with bit 31.
- R4: A `frame_start` pulse closes the bank being written and starts its readout. The following words go to the other bank while that readout runs. Frame numbers start at 0 after reset and increase by one at each swap.
- R5: At most DEPTH (600) words are stored per frame. Words accepted after that are dropped and set the overflow bit (trailer bit 0) for that frame only. The next frame starts with the bit clear.
- R6: A frame with no accepted words is sent as a header, a count word of 0 and a trailer.
- R7: A `frame_start` that arrives while a readout is running produces a one-cycle `late_swap` pulse in the next cycle. `in_ready` stays low until that readout ends. The closed frame is then sent with the next frame number.
- R8: A `frame_start` pulse that arrives while a delayed swap is already waiting has no effect: no extra frame is sent.
- R9: A word accepted in the same cycle as a `frame_start` that swaps at once is stored as word 0 of the new frame, not the closing frame.
- R10: Outside a frame readout, every lane is 0 and `ser_mark` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit period per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that closes the current frame |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block accepts the input word this cycle |
| in_data | input | 32 | Zero-suppressed data word |
| ser_lane | output | LANES (2) | Serial data lanes |
| ser_mark | output | 1 | Frame marker, high during header bits |
| late_swap | output | 1 | Pulse: frame closed while readout was busy |

## Verification
Two events can coincide in one cycle: a bank swap and a word acceptance, and a late frame close and the end of a readout. The bench raises `frame_start` and `in_valid` in the same cycle on an idle block. It then decodes the next two readouts from the lanes to confirm that the word opens the new frame and the closing frame stays empty. It also closes a frame a few cycles into a busy readout and closes it again while the first request is still waiting. Those two pulses are judged by the `late_swap` pulse, by `in_ready` staying low until the readout drains, by the next frame number and count in the delayed readout, and by the absence of any third readout.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
  localparam int WORD_W = 32;
  localparam int FNUM_W = 16;
  localparam logic [15:0] HDR_TAG = 16'hA55A;
  localparam logic [15:0] TRL_TAG = 16'h5AA5;

  typedef enum logic [2:0] {P_IDLE, P_HDR, P_CNT, P_DAT, P_TRL} phase_t;

  function automatic logic [WORD_W-1:0] mk_hdr(input logic [FNUM_W-1:0] fnum);
    return {HDR_TAG, fnum};
  endfunction

  function automatic logic [WORD_W-1:0] mk_cnt(input logic [15:0] n);
    return {16'h0000, n};
  endfunction

  function automatic logic [WORD_W-1:0] mk_trl(input logic ovf);
    return {TRL_TAG, 15'b0, ovf};
  endfunction
endpackage

// File: rtl/ppf_bank.sv
module ppf_bank #(
  parameter int W     = 32,
  parameter int DEPTH = 600,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ppf_reader.sv
module ppf_reader
  import ppf_pkg::*;
#(
  parameter int DEPTH = 600,
  parameter int LANES = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int BPL  = WORD_W / LANES,
  localparam int BCW  = (BPL > 1) ? $clog2(BPL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FNUM_W-1:0] fnum,
  input  logic [CW-1:0]     count,
  input  logic              ovf,
  output logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic [LANES-1:0]  lanes,
  output logic              marker
);
  phase_t              phase;
  logic [BCW-1:0]      bitcnt;
  logic [CW-1:0]       idx;
  logic [CW-1:0]       n_lat;
  logic                ovf_lat;
  logic [WORD_W-1:0]   shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= P_IDLE;
      bitcnt  <= '0;
      idx     <= '0;
      n_lat   <= '0;
      ovf_lat <= 1'b0;
      shreg   <= '0;
    end else if (start) begin
      phase   <= P_HDR;
      bitcnt  <= '0;
      idx     <= '0;
      n_lat   <= count;
      ovf_lat <= ovf;
      shreg   <= mk_hdr(fnum);
    end else if (phase != P_IDLE) begin
      if (bitcnt == BCW'(BPL - 1)) begin
        bitcnt <= '0;
        unique case (phase)
          P_HDR: begin
            phase <= P_CNT;
            shreg <= mk_cnt(16'(n_lat));
          end
          P_CNT, P_DAT: begin
            if (idx < n_lat) begin
              phase <= P_DAT;
              shreg <= rd_data;
              idx   <= idx + 1'b1;
            end else begin
              phase <= P_TRL;
              shreg <= mk_trl(ovf_lat);
            end
          end
          P_TRL: begin
            phase <= P_IDLE;
            shreg <= '0;
          end
          default: phase <= P_IDLE;
        endcase
      end else begin
        bitcnt <= bitcnt + 1'b1;
        shreg  <= shreg << LANES;
      end
    end
  end

  assign rd_addr = idx[AW-1:0];
  assign busy    = (phase != P_IDLE);
  assign marker  = (phase == P_HDR);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanes[k] = shreg[WORD_W-1-k];
  end

  // R7
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R2
  data_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_DAT) |-> (idx != '0 && idx <= n_lat));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lanes == '0));
endmodule

// File: rtl/frame_pingpong_tx.sv
module frame_pingpong_tx
  import ppf_pkg::*;
#(
  parameter int DEPTH = 600,
  parameter int LANES = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic [LANES-1:0]  ser_lane,
  output logic              ser_mark,
  output logic              late_swap
);
  logic              wr_sel;
  logic [CW-1:0]     wcount;
  logic              wovf;
  logic              pending;
  logic [FNUM_W-1:0] fnum;
  logic              rd_busy;
  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] bank_rdata [2];

  logic          swap_now, accept, wr_bank, we_any;
  logic [AW-1:0] waddr;

  assign swap_now = !rd_busy && (pending || frame_start);
  assign in_ready = !pending && !(frame_start && rd_busy);
  assign accept   = in_valid && in_ready;
  assign wr_bank  = swap_now ? ~wr_sel : wr_sel;
  assign we_any   = accept && (swap_now || (wcount < CW'(DEPTH)));
  assign waddr    = swap_now ? '0 : wcount[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_sel    <= 1'b0;
      wcount    <= '0;
      wovf      <= 1'b0;
      pending   <= 1'b0;
      fnum      <= '0;
      late_swap <= 1'b0;
    end else begin
      late_swap <= frame_start && rd_busy && !pending;
      if (swap_now) begin
        wr_sel  <= ~wr_sel;
        wcount  <= accept ? CW'(1) : '0;
        wovf    <= 1'b0;
        fnum    <= fnum + 1'b1;
        pending <= 1'b0;
      end else begin
        if (accept) begin
          if (wcount < CW'(DEPTH)) wcount <= wcount + 1'b1;
          else                     wovf   <= 1'b1;
        end
        if (frame_start && rd_busy) pending <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ppf_bank #(.W(WORD_W), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .we    (we_any && (wr_bank == 1'(b))),
      .waddr (waddr),
      .wdata (in_data),
      .raddr (rd_addr),
      .rdata (bank_rdata[b])
    );
  end

  ppf_reader #(.DEPTH(DEPTH), .LANES(LANES)) u_reader (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (swap_now),
    .fnum    (fnum),
    .count   (wcount),
    .ovf     (wovf),
    .rd_addr (rd_addr),
    .rd_data (bank_rdata[~wr_sel]),
    .busy    (rd_busy),
    .lanes   (ser_lane),
    .marker  (ser_mark)
  );

  // R5
  word_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcount <= CW'(DEPTH));
  // R7
  late_sets_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_swap |-> (pending && !in_ready));
  // R4
  swap_starts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_now |=> rd_busy);
endmodule

// File: tb/test_frame_pingpong_tx.sv
module test_frame_pingpong_tx;
  localparam int DEPTH = 600;
  localparam int LANES = 2;
  localparam int W     = 32;
  localparam int BPL   = W / LANES;

  // stimulus/expected vectors: {word count, seed}; expected count equals word count, overflow 0
  localparam logic [63:0] VEC [4] = '{
    {32'd5,  32'h1234_0000},
    {32'd1,  32'h8000_0001},
    {32'd17, 32'hC3A5_5A3C},
    {32'd0,  32'h0000_0000}
  };

  logic clk = 0, rst_n = 0;
  logic frame_start = 0, in_valid = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, ser_mark, late_swap;
  logic [LANES-1:0] ser_lane;

  frame_pingpong_tx #(.DEPTH(DEPTH), .LANES(LANES)) i_frame_pingpong_tx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .ser_lane(ser_lane),
    .ser_mark(ser_mark), .late_swap(late_swap));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int n_frames = 0, idle_err = 0, mk_err = 0;
  logic cap_on = 0;
  int bp = 0, wi = 0;
  logic [W-1:0] sh, cap_hdr, cap_cnt, cap_trl;
  logic [W-1:0] cap_w [1024];

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word_of(input logic [W-1:0] seed, input int j);
    return seed ^ (32'(j) * 32'h0101_0103) ^ (32'(j) << 19);
  endfunction

  // lane decoder, built from R2/R3
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cap_on) begin
        if (ser_mark) begin cap_on = 1; bp = 0; wi = 0; sh = '0; end
        else if (ser_lane != '0) idle_err++;
      end
      if (cap_on) begin
        for (int k = 0; k < LANES; k++) sh = {sh[W-2:0], ser_lane[k]};
        if (ser_mark != (wi == 0)) mk_err++;
        bp++;
        if (bp == BPL) begin
          bp = 0;
          if (wi == 0) cap_hdr = sh;
          else if (wi == 1) cap_cnt = sh;
          else if (wi < int'(cap_cnt[15:0]) + 2) begin
            if (wi - 2 < 1024) cap_w[wi-2] = sh;
          end else begin
            cap_trl = sh; cap_on = 0; n_frames++;
          end
          wi++;
        end
      end
    end
  end

  task automatic push(input logic [W-1:0] d);
    in_valid = 1; in_data = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic pulse_sof();
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic wait_frames(input int k);
    while (n_frames < k) @(negedge clk);
  endtask

  task automatic check_frame(input int fno, input int n, input logic [W-1:0] seed,
                             input bit ovf, input string req);
    int bad = -1;
    chk(cap_hdr == {16'hA55A, 16'(fno)}, {req, " R2 header"}, cap_hdr, {16'hA55A, 16'(fno)});
    chk(cap_cnt == {16'h0, 16'(n)}, {req, " R2 count"}, cap_cnt, {16'h0, 16'(n)});
    for (int j = 0; j < n; j++) if (bad < 0 && cap_w[j] != word_of(seed, j)) bad = j;
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, {req, " R3 data word"}, cap_w[bad], word_of(seed, bad));
    chk(cap_trl == {16'h5AA5, 15'b0, ovf}, {req, " R2 trailer"}, cap_trl, {16'h5AA5, 15'b0, ovf});
    chk(mk_err == 0, {req, " R2 marker"}, mk_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ser_lane == 0 && !ser_mark && !late_swap, "R1 outputs in reset", {ser_lane, ser_mark, late_swap}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(ser_lane == 0 && !ser_mark && !late_swap && in_ready, "R1 after reset",
        {ser_lane, ser_mark, late_swap, in_ready}, 1);

    // vector walk: R4 ping-pong, next frame filled during readout
    for (int j = 0; j < int'(VEC[0][63:32]); j++) push(word_of(VEC[0][31:0], j));
    for (int i = 0; i < 4; i++) begin
      pulse_sof();
      if (i < 3) for (int j = 0; j < int'(VEC[i+1][63:32]); j++) push(word_of(VEC[i+1][31:0], j));
      wait_frames(i + 1);
      check_frame(i, int'(VEC[i][63:32]), VEC[i][31:0], 0, "R4 vector");
    end

    // R9: word on the same cycle as an immediate swap opens the new frame
    frame_start = 1; in_valid = 1; in_data = word_of(32'h0BAD_F00D, 0);
    @(negedge clk);
    frame_start = 0; in_valid = 0;
    push(word_of(32'h0BAD_F00D, 1));
    wait_frames(5);
    check_frame(4, 0, 0, 0, "R6 empty frame");
    pulse_sof();
    wait_frames(6);
    check_frame(5, 2, 32'h0BAD_F00D, 0, "R9 same-cycle word");

    // R5: overflow
    for (int j = 0; j < DEPTH + 3; j++) push(word_of(32'h7E57_0000, j));
    pulse_sof();
    wait_frames(7);
    check_frame(6, DEPTH, 32'h7E57_0000, 1, "R5 overflow");
    push(word_of(32'h2222_0000, 0));
    push(word_of(32'h2222_0000, 1));
    pulse_sof();
    wait_frames(8);
    check_frame(7, 2, 32'h2222_0000, 0, "R5 flag cleared next frame");

    // R7/R8: late swap and ignored second request
    for (int j = 0; j < 3; j++) push(word_of(32'h3333_0000, j));
    pulse_sof();
    repeat (5) @(negedge clk);
    pulse_sof();
    #1;
    chk(late_swap == 1, "R7 late_swap pulse", late_swap, 1);
    chk(in_ready == 0, "R7 in_ready low while waiting", in_ready, 0);
    repeat (5) @(negedge clk);
    pulse_sof();
    push(word_of(32'h4444_0000, 0));
    chk(n_frames >= 9, "R7 stall until readout end", n_frames, 9);
    wait_frames(9);
    check_frame(8, 3, 32'h3333_0000, 0, "R7 busy frame");
    wait_frames(10);
    check_frame(9, 0, 0, 0, "R7 delayed frame");
    repeat (300) @(negedge clk);
    chk(n_frames == 10, "R8 extra request ignored", n_frames, 10);
    pulse_sof();
    wait_frames(11);
    check_frame(10, 1, 32'h4444_0000, 0, "R8 following frame");

    repeat (4) @(negedge clk);
    chk(idle_err == 0, "R10 idle lanes", idle_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule